// File: doc/BRIEF.md
# Multipurpose Register Ripple Queue

This block keeps three 32-bit entries behind one bus register address. Software writing the register fills all three entries with the written value. Software reading the register gets the head entry, and the queue then moves forward by one place, so repeated reads of the same address return successive words. The last entry keeps its value when the queue moves.

The command sequencer of a disk controller can also load the queue when a command completes. A get-status completion composes a drive status word and copies it into every entry. A read-header completion puts a header word (current cylinder/track position and requested sector) at the head, zeroes the other two entries and raises a one-cycle attention pulse for the addressed drive.

The status word depends on the drive type. Large-type drives report fixed ready and media flags. Small-type drives report a lock-on code and latched error conditions. Those errors are held per drive and can be cleared by a get-status completion when the last value written by software had its clear bit set.

Top module: `mp_ripple_queue`

## Requirements
- R1: While reset is active, and after it, all entries are zero and the attention output is zero. A bus read right after reset returns 0.
- R2: A bus write stores the written value into all three entries, so the next three reads return that value.
- R3: `busRdData` always shows the head entry. A bus read strobe moves entry 1 to the head and entry 2 to entry 1, and entry 2 keeps its value. After a write of A, a fourth read still returns A.
- R4: A read-header load (`loadKind`=1) puts `{headerPos, headerSector}` in the head (position in bits 31:8, sector in bits 7:0) and zeroes entries 1 and 2. In the cycle after the load edge, `attnPulse` has exactly the bit of `loadDrive` set, and it is zero otherwise.
- R5: A get-status load (`loadKind`=0) on a large-type drive gives a word with bit 9 always set, bits 12 and 11 set when media is attached, bit 13 set when the drive is write-protected, and all other bits zero.
- R6: A get-status load on a small-type drive gives, when attached, lock code 5 in bits 2:0 plus bit 3 (brushes home) and bit 4 (heads out), which is 0x1D, and 0 when not attached. Bit 13 is set when write-protected. Latched errors appear as bit 9 (volume check, set by `volChkEvt`), bit 10 (write-gate error, set by `gateErrEvt`) and bit 11 (spin error, set by `spinErrEvt`).
- R7: Latched small-drive errors stay set across status loads. If bit 3 of the most recent bus write was 1, a small-drive get-status clears that drive's latched errors before the word is composed, so the reported word shows none of them.
- R8: A load request wins over a bus write or a bus read in the same cycle, and a bus write wins over a bus read. The read still returns the old head, but the queue is not shifted.
- R9: After a get-status load, all three entries hold the same status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe (shifts the queue) |
| busWrData | input | 32 | Bus write value |
| busRdData | output | 32 | Head entry |
| loadReq | input | 1 | Command completion load request |
| loadKind | input | 1 | 0 = get-status, 1 = read-header |
| loadDrive | input | 2 | Drive addressed by the completing command |
| headerPos | input | 24 | Current cylinder/track field for the header |
| headerSector | input | 8 | Requested sector for the header |
| driveIsLarge | input | 4 | Per-drive type, 1 = large type |
| driveAttached | input | 4 | Per-drive media attached |
| driveWrProt | input | 4 | Per-drive write protect |
| volChkEvt | input | 4 | Per-drive volume check event |
| gateErrEvt | input | 4 | Per-drive write-gate error event |
| spinErrEvt | input | 4 | Per-drive spin error event |
| attnPulse | output | 4 | One-cycle attention pulse after a read-header load |

## Verification
A wrong entry shows up within the next one to four reads at `busRdData`. A stuck or wrongly filled tail entry is caught by reading past the point where a zero-fill and a hold would return different values. A wrong priority decision shows at the next read: the head is either shifted or missing the loaded word. A latched error that is lost, or fails to clear, is visible in the very next status word composed for that drive.

// File: rtl/mpq_pkg.sv
package mpq_pkg;

  typedef enum logic {
    LOAD_STATUS = 1'b0,
    LOAD_HEADER = 1'b1
  } loadKind_e;

  typedef struct packed {
    logic doWrite;
    logic doShift;
    logic doStatus;
    logic doHeader;
    logic doClear;
  } qStrobe_t;

  // status bit positions shared by the composer
  localparam int LARGE_PRESENT_BIT = 9;
  localparam int LARGE_ONCYL_BIT   = 11;
  localparam int LARGE_READY_BIT   = 12;
  localparam int WRLOCK_BIT        = 13;
  localparam int SMALL_VCK_BIT     = 9;
  localparam int SMALL_WGE_BIT     = 10;
  localparam int SMALL_SPE_BIT     = 11;
  localparam int SMALL_ATT_CODE    = 'h1D;
  localparam int CLEAR_ARM_BIT     = 3;

endpackage

// File: rtl/mpq_ctrl.sv
module mpq_ctrl
  import mpq_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  localparam int DRV_W = $clog2(NUM_DRIVES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic                  wrArmBit,
  input  logic                  loadReq,
  input  logic                  loadKind,
  input  logic [DRV_W-1:0]      loadDrive,
  input  logic [NUM_DRIVES-1:0] driveIsLarge,
  output qStrobe_t              strobe,
  output logic [NUM_DRIVES-1:0] attnPulse
);

  logic clrArm;
  logic isStatus;
  logic isHeader;

  assign isStatus = loadReq && (loadKind == LOAD_STATUS);
  assign isHeader = loadReq && (loadKind == LOAD_HEADER);

  // priority: load > write > read
  always_comb begin
    strobe          = '0;
    strobe.doStatus = isStatus;
    strobe.doHeader = isHeader;
    strobe.doWrite  = busWrEn && !loadReq;
    strobe.doShift  = busRdEn && !loadReq && !busWrEn;
    strobe.doClear  = isStatus && !driveIsLarge[loadDrive] && clrArm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clrArm    <= 1'b0;
      attnPulse <= '0;
    end else begin
      if (strobe.doWrite) clrArm <= wrArmBit;
      attnPulse <= isHeader ? (NUM_DRIVES'(1) << loadDrive) : '0;
    end
  end

  // R4: attention pulse marks only the addressed drive, one cycle later
  a_r4_attn_one: assert property (@(posedge clk) disable iff (!rstN)
    isHeader |=> ($countones(attnPulse) == 1) && attnPulse[$past(loadDrive)]);

  a_r4_attn_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !isHeader |=> (attnPulse == '0));

endmodule

// File: rtl/mpq_status.sv
module mpq_status
  import mpq_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int DATA_W     = 32,
  localparam int DRV_W = $clog2(NUM_DRIVES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  qStrobe_t              strobe,
  input  logic [DRV_W-1:0]      selDrive,
  input  logic [NUM_DRIVES-1:0] driveIsLarge,
  input  logic [NUM_DRIVES-1:0] driveAttached,
  input  logic [NUM_DRIVES-1:0] driveWrProt,
  input  logic [NUM_DRIVES-1:0] volChkEvt,
  input  logic [NUM_DRIVES-1:0] gateErrEvt,
  input  logic [NUM_DRIVES-1:0] spinErrEvt,
  output logic [DATA_W-1:0]     statusWord
);

  // per drive: {spin, gate, volume check}
  logic [2:0] errLatch [NUM_DRIVES];

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
    logic clrHere;
    logic [2:0] setHere;
    assign clrHere = strobe.doClear && (selDrive == DRV_W'(d));
    assign setHere = {spinErrEvt[d], gateErrEvt[d], volChkEvt[d]};

    always_ff @(posedge clk) begin
      if (!rstN) errLatch[d] <= '0;
      else       errLatch[d] <= (clrHere ? 3'b000 : errLatch[d]) | setHere;
    end

    // R6: each error event is remembered
    a_r6_latch_set: assert property (@(posedge clk) disable iff (!rstN)
      (setHere != 3'b000) |=> ((errLatch[d] & $past(setHere)) == $past(setHere)));

    // R7: a clear with no new event leaves nothing latched
    a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
      (clrHere && (setHere == 3'b000)) |=> (errLatch[d] == 3'b000));
  end

  logic [2:0]        errView;
  logic [DATA_W-1:0] largeWord;
  logic [DATA_W-1:0] smallWord;

  always_comb begin
    errView = strobe.doClear ? 3'b000 : errLatch[selDrive];

    largeWord = '0;
    largeWord[LARGE_PRESENT_BIT] = 1'b1;
    largeWord[LARGE_ONCYL_BIT]   = driveAttached[selDrive];
    largeWord[LARGE_READY_BIT]   = driveAttached[selDrive];
    largeWord[WRLOCK_BIT]        = driveWrProt[selDrive];

    smallWord = driveAttached[selDrive] ? DATA_W'(SMALL_ATT_CODE) : '0;
    smallWord[SMALL_VCK_BIT] = errView[0];
    smallWord[SMALL_WGE_BIT] = errView[1];
    smallWord[SMALL_SPE_BIT] = errView[2];
    smallWord[WRLOCK_BIT]    = driveWrProt[selDrive];

    statusWord = driveIsLarge[selDrive] ? largeWord : smallWord;
  end

endmodule

// File: rtl/mpq_datapath.sv
module mpq_datapath
  import mpq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SECT_W = 8,
  parameter int DEPTH  = 3,
  localparam int POS_W = DATA_W - SECT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] statusWord,
  input  logic [POS_W-1:0]  headerPos,
  input  logic [SECT_W-1:0] headerSector,
  output logic [DATA_W-1:0] headData
);

  logic [DATA_W-1:0] entry [DEPTH];
  logic [DATA_W-1:0] hdrWord;

  assign hdrWord  = {headerPos, headerSector};
  assign headData = entry[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DATA_W-1:0] shiftIn;
    logic [DATA_W-1:0] hdrIn;
    if (i < DEPTH - 1) begin : g_mid
      assign shiftIn = entry[i+1];
    end else begin : g_tail
      assign shiftIn = entry[i];
    end
    if (i == 0) begin : g_head
      assign hdrIn = hdrWord;
    end else begin : g_rest
      assign hdrIn = '0;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                entry[i] <= '0;
      else if (strobe.doStatus) entry[i] <= statusWord;
      else if (strobe.doHeader) entry[i] <= hdrIn;
      else if (strobe.doWrite)  entry[i] <= wrData;
      else if (strobe.doShift)  entry[i] <= shiftIn;
    end
  end

  // R2: a write fills every entry
  a_r2_fill: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doWrite |=> (entry[0] == $past(wrData)) && (entry[1] == $past(wrData))
                       && (entry[2] == $past(wrData)));

  // R3: read moves the queue forward, tail holds
  a_r3_shift: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doShift |=> (entry[0] == $past(entry[1])) && (entry[1] == $past(entry[2]))
                       && (entry[2] == $past(entry[2])));

  // R4: header leaves zeros behind the head
  a_r4_tail_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doHeader |=> (entry[1] == '0) && (entry[2] == '0)
                        && (entry[0] == $past(hdrWord)));

  // R9: status copies one word to all entries
  a_r9_equal: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doStatus |=> (entry[0] == entry[1]) && (entry[1] == entry[2]));

  // R8: no shift when a load or write takes the cycle
  a_r8_no_shift: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doStatus || strobe.doHeader) |-> !strobe.doShift && !strobe.doWrite);

endmodule

// File: rtl/mp_ripple_queue.sv
module mp_ripple_queue
  import mpq_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int DATA_W     = 32,
  parameter int SECT_W     = 8,
  localparam int DRV_W = $clog2(NUM_DRIVES),
  localparam int POS_W = DATA_W - SECT_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  input  logic                  loadReq,
  input  logic                  loadKind,
  input  logic [DRV_W-1:0]      loadDrive,
  input  logic [POS_W-1:0]      headerPos,
  input  logic [SECT_W-1:0]     headerSector,
  input  logic [NUM_DRIVES-1:0] driveIsLarge,
  input  logic [NUM_DRIVES-1:0] driveAttached,
  input  logic [NUM_DRIVES-1:0] driveWrProt,
  input  logic [NUM_DRIVES-1:0] volChkEvt,
  input  logic [NUM_DRIVES-1:0] gateErrEvt,
  input  logic [NUM_DRIVES-1:0] spinErrEvt,
  output logic [NUM_DRIVES-1:0] attnPulse
);

  qStrobe_t          strobe;
  logic [DATA_W-1:0] statusWord;

  mpq_ctrl #(.NUM_DRIVES(NUM_DRIVES)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .busWrEn     (busWrEn),
    .busRdEn     (busRdEn),
    .wrArmBit    (busWrData[CLEAR_ARM_BIT]),
    .loadReq     (loadReq),
    .loadKind    (loadKind),
    .loadDrive   (loadDrive),
    .driveIsLarge(driveIsLarge),
    .strobe      (strobe),
    .attnPulse   (attnPulse)
  );

  mpq_status #(.NUM_DRIVES(NUM_DRIVES), .DATA_W(DATA_W)) uStatus (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .selDrive     (loadDrive),
    .driveIsLarge (driveIsLarge),
    .driveAttached(driveAttached),
    .driveWrProt  (driveWrProt),
    .volChkEvt    (volChkEvt),
    .gateErrEvt   (gateErrEvt),
    .spinErrEvt   (spinErrEvt),
    .statusWord   (statusWord)
  );

  mpq_datapath #(.DATA_W(DATA_W), .SECT_W(SECT_W), .DEPTH(3)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (busWrData),
    .statusWord  (statusWord),
    .headerPos   (headerPos),
    .headerSector(headerSector),
    .headData    (busRdData)
  );

  // R1: reset empties the head
  a_r1_reset_head: assert property (@(posedge clk)
    !rstN |=> (busRdData == '0) && (attnPulse == '0));

endmodule

// File: tb/tb_mp_ripple_queue.sv
`timescale 1ns/1ps
module tb_mp_ripple_queue;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busWrEn, busRdEn;
  logic [31:0] busWrData, busRdData;
  logic        loadReq, loadKind;
  logic [1:0]  loadDrive;
  logic [23:0] headerPos;
  logic [7:0]  headerSector;
  logic [3:0]  driveIsLarge, driveAttached, driveWrProt;
  logic [3:0]  volChkEvt, gateErrEvt, spinErrEvt;
  logic [3:0]  attnPulse;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mp_ripple_queue dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .loadReq(loadReq),
    .loadKind(loadKind), .loadDrive(loadDrive), .headerPos(headerPos),
    .headerSector(headerSector), .driveIsLarge(driveIsLarge),
    .driveAttached(driveAttached), .driveWrProt(driveWrProt),
    .volChkEvt(volChkEvt), .gateErrEvt(gateErrEvt), .spinErrEvt(spinErrEvt),
    .attnPulse(attnPulse)
  );

  // vector: {isRead, writeData, expectedRead}
  localparam logic [64:0] VEC [13] = '{
    {1'b0, 32'hDEADBEEF, 32'h0},
    {1'b1, 32'h0, 32'hDEADBEEF},
    {1'b1, 32'h0, 32'hDEADBEEF},
    {1'b1, 32'h0, 32'hDEADBEEF},
    {1'b1, 32'h0, 32'hDEADBEEF},
    {1'b0, 32'h12345670, 32'h0},
    {1'b1, 32'h0, 32'h12345670},
    {1'b0, 32'hA5A5_0F0F, 32'h0},
    {1'b1, 32'h0, 32'hA5A5_0F0F},
    {1'b1, 32'h0, 32'hA5A5_0F0F},
    {1'b1, 32'h0, 32'hA5A5_0F0F},
    {1'b1, 32'h0, 32'hA5A5_0F0F},
    {1'b0, 32'h0000_0000, 32'h0}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [31:0] v);
    busWrEn = 1'b1; busWrData = v;
    step();
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input string req, input logic [31:0] exp);
    busRdEn = 1'b1;
    check(req, busRdData, exp);
    step();
    busRdEn = 1'b0;
  endtask

  task automatic loadStatus(input logic [1:0] drv);
    loadReq = 1'b1; loadKind = 1'b0; loadDrive = drv;
    step();
    loadReq = 1'b0;
  endtask

  task automatic readThree(input string req, input logic [31:0] exp);
    for (int k = 0; k < 3; k++) busRead(req, exp);
  endtask

  initial begin
    #(2000 * 5);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busWrEn = 0; busRdEn = 0; busWrData = '0;
    loadReq = 0; loadKind = 0; loadDrive = '0; headerPos = '0; headerSector = '0;
    driveIsLarge = 4'b0001; driveAttached = 4'b0011; driveWrProt = 4'b0000;
    volChkEvt = '0; gateErrEvt = '0; spinErrEvt = '0;
    step(); step();
    rstN = 1'b1;
    step();

    // R1 reset state
    check("R1 head", busRdData, 32'h0);
    check("R1 attn", {28'h0, attnPulse}, 32'h0);

    // R2 / R3 vector table
    for (int v = 0; v < 13; v++) begin
      if (VEC[v][64]) busRead("R2/R3 vec", VEC[v][31:0]);
      else            busWrite(VEC[v][63:32]);
    end

    // R4 read-header
    headerPos = 24'h0123_45; headerSector = 8'h1F;
    loadReq = 1'b1; loadKind = 1'b1; loadDrive = 2'd2;
    step();
    loadReq = 1'b0;
    check("R4 attn drive2", {28'h0, attnPulse}, 32'h4);
    check("R4 head", busRdData, 32'h0123451F);
    step();
    check("R4 attn drops", {28'h0, attnPulse}, 32'h0);
    busRead("R4 header word", 32'h0123451F);
    busRead("R4 zero1", 32'h0);
    busRead("R4 zero2", 32'h0);

    // R5 large-type status, R9 all entries equal
    driveWrProt = 4'b0001;
    loadStatus(2'd0);
    readThree("R5/R9 large att wp", 32'h0000_3A00);
    driveWrProt = 4'b0000;
    loadStatus(2'd0);
    busRead("R5 large att", 32'h0000_1A00);
    driveAttached[0] = 1'b0;
    loadStatus(2'd0);
    busRead("R5 large unattached", 32'h0000_0200);
    driveAttached[0] = 1'b1;

    // R6 small-type status
    busWrite(32'h0);
    loadStatus(2'd1);
    busRead("R6 small attached", 32'h0000_001D);
    volChkEvt[1] = 1'b1; step(); volChkEvt[1] = 1'b0;
    loadStatus(2'd1);
    readThree("R6/R9 small vck", 32'h0000_021D);
    // R7 errors stay without arm
    loadStatus(2'd1);
    busRead("R7 kept", 32'h0000_021D);
    gateErrEvt[1] = 1'b1; step(); gateErrEvt[1] = 1'b0;
    loadStatus(2'd1);
    busRead("R6 small vck+wge", 32'h0000_061D);
    spinErrEvt[3] = 1'b1; driveWrProt[3] = 1'b1; step(); spinErrEvt[3] = 1'b0;
    loadStatus(2'd3);
    busRead("R6 small unatt spe wp", 32'h0000_2800);
    // R7 clear via bit 3 of last write
    busWrite(32'h0000_0008);
    loadStatus(2'd1);
    busRead("R7 cleared", 32'h0000_001D);
    busWrite(32'h0);
    loadStatus(2'd1);
    busRead("R7 stays cleared", 32'h0000_001D);

    // R8 load over read
    busWrite(32'h1111_2222);
    headerPos = 24'hABCDEF; headerSector = 8'h05; loadDrive = 2'd1;
    loadReq = 1'b1; loadKind = 1'b1; busRdEn = 1'b1;
    check("R8 read returns old head", busRdData, 32'h1111_2222);
    step();
    loadReq = 1'b0; busRdEn = 1'b0;
    busRead("R8 header not shifted", 32'hABCDEF05);
    // R8 load over write
    busWrEn = 1'b1; busWrData = 32'h5555_5555;
    loadReq = 1'b1; loadKind = 1'b0; loadDrive = 2'd0;
    step();
    busWrEn = 1'b0; loadReq = 1'b0;
    busRead("R8 status beats write", 32'h0000_1A00);
    // R8 write over read
    busWrite(32'h7777_0000);
    busWrEn = 1'b1; busRdEn = 1'b1; busWrData = 32'h9999_AAAA;
    check("R8 read old", busRdData, 32'h7777_0000);
    step();
    busWrEn = 1'b0; busRdEn = 1'b0;
    readThree("R8 write beats read", 32'h9999_AAAA);

    // R1 reset mid-run
    busWrite(32'hCAFE_F00D);
    rstN = 1'b0; step(); rstN = 1'b1;
    check("R1 reset clears", busRdData, 32'h0);
    step();
    readThree("R1 all zero", 32'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule